// File: doc/BRIEF.md
# Burst Address Generator

This block forms the array address of a synchronous burst memory. An external address is captured when one of two address strobes is accepted. One strobe is meant for a processor and one for a memory controller. The block then holds the upper address bits and steps the two lowest bits on each cycle that the advance input is high. A burst therefore has four beats, and after the fourth beat the low bits return to their start value. The low bits follow a linear order or an interleaved order, chosen by a mode input.

Chip-enable qualification decides whether a strobe starts an access, ends the current access, or has no effect. Bursting is optional. The user may present a fresh address and strobe on every cycle. All inputs are sampled on the rising clock edge, and the address output is a register.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the next value is `addr_out` = 0 and `burst_active` = 0.
- R2: A processor strobe (`cpu_strobe`=1) with `enable_pri`=1 loads `addr_in` into `addr_out`, starts a burst at beat 0 and sets `burst_active`=1. The value of `enable_aux` does not matter.
- R3: A controller strobe (`ctl_strobe`=1) with no accepted processor strobe, and with both `enable_pri`=1 and `enable_aux`=1, loads `addr_in` and sets `burst_active`=1.
- R4: When both strobes are high and `enable_pri`=1, the processor strobe decides the outcome. With `enable_aux`=0 the address still loads, even though a controller strobe alone would deselect.
- R5: A processor strobe with `enable_pri`=0 is ignored. The cycle then behaves as if that strobe were low.
- R6: A controller strobe that decides the cycle while either enable is low deselects. `burst_active` becomes 0 and `addr_out` keeps its value.
- R7: `advance`=1 with no deciding strobe and `burst_active`=1 steps the 2-bit beat count by one, modulo 4. The upper bits of `addr_out` stay unchanged.
- R8: With `order_linear`=1 the low two bits of `addr_out` equal (start + beat) mod 4. For example, a start of 2 gives the sequence 2,3,0,1 and then 2 again.
- R9: With `order_linear`=0 (interleaved, the intended default) the low two bits equal start XOR beat. For example, a start of 1 gives the sequence 1,0,3,2.
- R10: With no deciding strobe and `advance`=0, `addr_out` and `burst_active` hold.
- R11: Accepted strobes on consecutive cycles each load their own address, with no idle cycle between them.
- R12: `advance`=1 while `burst_active`=0 has no effect, and `addr_out` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W | External address |
| cpu_strobe | input | 1 | Processor-side address strobe, highest priority |
| ctl_strobe | input | 1 | Controller-side address strobe |
| advance | input | 1 | Step the burst by one beat |
| enable_pri | input | 1 | Primary chip enable, active high |
| enable_aux | input | 1 | Secondary chip enable, active high |
| order_linear | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_out | output | ADDR_W | Current array address (registered) |
| burst_active | output | 1 | An access is open |

## Verification
Every result of this block appears exactly one rising edge after the inputs that cause it. This covers a load, a step, a deselect and a hold alike, because the only state is the address register and the burst state beside it. The bench drives each vector on the falling edge and waits for the next rising edge. It compares shortly after that edge against a reference model that has been advanced by the same one step, so no check reads a value that is still changing. Directed runs cover wrap-around in both orders, strobe priority, ignored strobes and deselects. Seeded random vectors then mix all the commands.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    // Width of the internal beat counter: four beats per burst.
    localparam int BURST_W = 2;

    typedef logic [BURST_W-1:0] beat_t;

    // Decision taken for one clock cycle.
    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_STEP  = 2'd2,
        CMD_DESEL = 2'd3
    } cmd_e;

    // Sampled control inputs of one cycle.
    typedef struct packed {
        logic cpu_stb;
        logic ctl_stb;
        logic adv;
        logic en_pri;
        logic en_aux;
    } ctl_in_t;

    // Low address bits for a given start value and beat.
    function automatic beat_t seq_low(input beat_t start, input beat_t beat,
                                      input logic linear);
        beat_t r;
        if (linear) r = beat_t'(start + beat);
        else        r = start ^ beat;
        return r;
    endfunction

endpackage

// File: rtl/burst_strobe_qual.sv
module burst_strobe_qual
    import burst_addr_pkg::*;
(
    input  ctl_in_t ctl,
    input  logic    active,
    output cmd_e    cmd
);
    logic cpu_take;
    logic ctl_open;

    // The processor strobe counts only when the primary enable is high.
    assign cpu_take = ctl.cpu_stb && ctl.en_pri;
    assign ctl_open = ctl.en_pri && ctl.en_aux;

    always_comb begin
        cmd = CMD_HOLD;
        if (cpu_take) begin
            cmd = CMD_LOAD;
        end else if (ctl.ctl_stb) begin
            cmd = ctl_open ? CMD_LOAD : CMD_DESEL;
        end else if (ctl.adv && active) begin
            cmd = CMD_STEP;
        end
    end
endmodule

// File: rtl/burst_beat_seq.sv
module burst_beat_seq
    import burst_addr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cmd_e  cmd,
    input  beat_t load_lo,
    input  logic  order_linear,
    output beat_t low_q
);
    beat_t start_q;
    beat_t beat_q;
    beat_t beat_nx;

    assign beat_nx = beat_t'(beat_q + 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            beat_q  <= '0;
            low_q   <= '0;
        end else begin
            case (cmd)
                CMD_LOAD: begin
                    start_q <= load_lo;
                    beat_q  <= '0;
                    low_q   <= load_lo;
                end
                CMD_STEP: begin
                    beat_q <= beat_nx;
                    low_q  <= seq_low(start_q, beat_nx, order_linear);
                end
                default: ;
            endcase
        end
    end

    AST_LOAD_LOW: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD) |=> (low_q == $past(load_lo)));            // R2

    AST_NONSTEP_LOW: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_HOLD || cmd == CMD_DESEL) |=> $stable(low_q));     // R10
endmodule

// File: rtl/burst_upper_reg.sv
module burst_upper_reg
    import burst_addr_pkg::*;
#(
    parameter int HI_W = 17
) (
    input  logic            clk,
    input  logic            rst,
    input  cmd_e            cmd,
    input  logic [HI_W-1:0] load_hi,
    output logic [HI_W-1:0] hi_q,
    output logic            active_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q     <= '0;
            active_q <= 1'b0;
        end else begin
            case (cmd)
                CMD_LOAD: begin
                    hi_q     <= load_hi;
                    active_q <= 1'b1;
                end
                CMD_DESEL: active_q <= 1'b0;
                default: ;
            endcase
        end
    end

    AST_HI_KEEP_STEP: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_STEP) |=> ($stable(hi_q) && active_q));            // R7
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              cpu_strobe,
    input  logic              ctl_strobe,
    input  logic              advance,
    input  logic              enable_pri,
    input  logic              enable_aux,
    input  logic              order_linear,
    output logic [ADDR_W-1:0] addr_out,
    output logic              burst_active
);
    localparam int HI_W = ADDR_W - BURST_W;

    ctl_in_t         ctl;
    cmd_e            cmd;
    beat_t           low_q;
    logic [HI_W-1:0] hi_q;

    assign ctl = '{cpu_stb: cpu_strobe, ctl_stb: ctl_strobe, adv: advance,
                   en_pri: enable_pri, en_aux: enable_aux};

    burst_strobe_qual u_qual (
        .ctl    (ctl),
        .active (burst_active),
        .cmd    (cmd)
    );

    burst_beat_seq u_beat (
        .clk          (clk),
        .rst          (rst),
        .cmd          (cmd),
        .load_lo      (addr_in[BURST_W-1:0]),
        .order_linear (order_linear),
        .low_q        (low_q)
    );

    burst_upper_reg #(.HI_W(HI_W)) u_upper (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .load_hi  (addr_in[ADDR_W-1:BURST_W]),
        .hi_q     (hi_q),
        .active_q (burst_active)
    );

    assign addr_out = {hi_q, low_q};

    AST_CPU_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cpu_strobe && enable_pri) |=>
        (addr_out == $past(addr_in) && burst_active));                  // R2

    AST_CTL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!cpu_strobe && ctl_strobe && enable_pri && enable_aux) |=>
        (addr_out == $past(addr_in) && burst_active));                  // R3

    AST_CPU_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cpu_strobe && !enable_pri && !ctl_strobe && !advance) |=>
        $stable(addr_out));                                             // R5

    AST_CTL_DESELECT: assert property (@(posedge clk) disable iff (rst)
        (!(cpu_strobe && enable_pri) && ctl_strobe && !(enable_pri && enable_aux)) |=>
        (!burst_active && $stable(addr_out)));                          // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!(cpu_strobe && enable_pri) && !ctl_strobe && !advance) |=>
        ($stable(addr_out) && $stable(burst_active)));                  // R10

    AST_ADV_INACTIVE: assert property (@(posedge clk) disable iff (rst)
        (!(cpu_strobe && enable_pri) && !ctl_strobe && !burst_active) |=>
        ($stable(addr_out) && !burst_active));                          // R12
endmodule

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb;
    localparam int AW = 19;
    localparam int WATCHDOG_CYC = 20000;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr_in;
    logic          cpu_strobe, ctl_strobe, advance;
    logic          enable_pri, enable_aux, order_linear;
    logic [AW-1:0] addr_out;
    logic          burst_active;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // Reference model state
    logic [AW-1:0] m_addr;
    logic          m_act;
    logic [1:0]    m_start, m_beat;

    always #2.5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .addr_in(addr_in),
        .cpu_strobe(cpu_strobe), .ctl_strobe(ctl_strobe), .advance(advance),
        .enable_pri(enable_pri), .enable_aux(enable_aux),
        .order_linear(order_linear),
        .addr_out(addr_out), .burst_active(burst_active)
    );

    function automatic logic [1:0] ref_low(logic [1:0] s, logic [1:0] b, logic lin);
        return lin ? 2'(s + b) : (s ^ b);
    endfunction

    task automatic model_step(logic c, logic k, logic a, logic p, logic x,
                              logic lin, logic [AW-1:0] ad);
        if (c && p) begin
            m_addr = ad; m_act = 1'b1; m_start = ad[1:0]; m_beat = 2'd0;
        end else if (k) begin
            if (p && x) begin
                m_addr = ad; m_act = 1'b1; m_start = ad[1:0]; m_beat = 2'd0;
            end else begin
                m_act = 1'b0;
            end
        end else if (a && m_act) begin
            m_beat = 2'(m_beat + 1);
            m_addr[1:0] = ref_low(m_start, m_beat, lin);
        end
    endtask

    task automatic compare(string tag);
        vectors++;
        if (addr_out !== m_addr || burst_active !== m_act) begin
            fails++;
            $display("FAIL %s: addr_out=%h active=%b expected addr_out=%h active=%b",
                     tag, addr_out, burst_active, m_addr, m_act);
        end
    endtask

    task automatic apply(logic c, logic k, logic a, logic p, logic x, logic lin,
                         logic [AW-1:0] ad, string tag);
        @(negedge clk);
        cpu_strobe = c; ctl_strobe = k; advance = a;
        enable_pri = p; enable_aux = x; order_linear = lin; addr_in = ad;
        model_step(c, k, a, p, x, lin, ad);
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1;
        cpu_strobe = 0; ctl_strobe = 0; advance = 0;
        enable_pri = 0; enable_aux = 0; order_linear = 0; addr_in = '0;
        m_addr = '0; m_act = 0; m_start = 0; m_beat = 0;
        repeat (3) @(posedge clk);
        #1;
        compare("R1 reset state");
        @(negedge clk);
        rst = 1'b0;

        // R8: linear burst from start 2 wraps after four beats
        apply(1,0,0,1,1,1, 19'h1A2B6, "R2 cpu load");
        for (int i = 0; i < 4; i++) apply(0,0,1,1,1,1, '0, "R8 linear step/wrap");
        // R9: interleaved burst from start 1
        apply(0,1,0,1,1,0, 19'h05551, "R3 ctl load");
        for (int i = 0; i < 4; i++) apply(0,0,1,1,1,0, '0, "R9 interleaved step");
        // R7: high bits kept during steps (covered by R8/R9 compares too)
        apply(0,0,1,1,1,0, '0, "R7 step keeps upper bits");
        // R10 hold
        apply(0,0,0,1,1,0, 19'h7FFFF, "R10 hold");
        // R4 priority: both strobes, aux low, cpu wins and loads
        apply(1,1,0,1,0,1, 19'h12343, "R4 cpu priority");
        // R5 cpu ignored with primary enable low
        apply(1,0,0,0,1,1, 19'h00000, "R5 cpu ignored");
        // R6 ctl deselect with aux low
        apply(0,1,0,1,0,1, 19'h0ABCD, "R6 ctl deselect");
        // R12 advance while inactive
        apply(0,0,1,1,1,1, '0, "R12 advance inactive");
        apply(1,0,1,0,1,1, 19'h11111, "R5 cpu ignored, adv inactive");
        // R11 back-to-back loads
        apply(1,0,0,1,1,0, 19'h00003, "R11 back-to-back load 1");
        apply(0,1,0,1,1,0, 19'h40002, "R11 back-to-back load 2");
        apply(1,0,1,1,0,0, 19'h2AAA1, "R11 back-to-back load 3");
        apply(0,0,1,1,1,0, '0, "R9 step after reload");
        // R1 reset mid-burst
        @(negedge clk); rst = 1'b1;
        m_addr = '0; m_act = 0; m_start = 0; m_beat = 0;
        @(posedge clk); #1; compare("R1 reset mid-burst");
        @(negedge clk); rst = 1'b0;

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic c, k, a, p, x, lin;
            logic [AW-1:0] ad;
            c   = ($urandom_range(0, 99) < 15);
            k   = ($urandom_range(0, 99) < 15);
            a   = ($urandom_range(0, 99) < 65);
            p   = ($urandom_range(0, 99) < 85);
            x   = ($urandom_range(0, 99) < 80);
            lin = ($urandom_range(0, 99) < 50);
            ad  = AW'($urandom);
            apply(c, k, a, p, x, lin, ad, "R2-R12 random mix");
        end

        finish_run();
    end
endmodule